// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block paces the master side of an I2C bus. A 6-bit rate code picks an SCL period in module clocks, together with the delay from the start of a low phase to the moment SDA may change. The start and stop hold times are worked out from that period. A byte engine above the block asks for one bus phase at a time: a START condition, one data bit, a repeated START or a STOP. The block drives the open-drain enables for SCL and SDA, where 1 pulls the line low. It raises a one-cycle tick when the phase completes.

Only fourteen codes are supported, in two groups. The upper group runs sixteen times slower than the lower group. A code outside both groups still gets bus timing: the block falls back to a configurable supported code and sets a sticky error flag. The rate code is read once, when a request is accepted, so a phase in progress keeps its timing.

Top module: `scl_timing_gen`

## Requirements
- R1: After a synchronous reset, scl_oe, sda_oe, done_tick, busy and rate_err are all 0, and the block is idle with the bus released.
- R2: Supported codes and their timing. Codes 0x19..0x1F give dividers 96, 112, 128, 144, 160, 192 and 240, with SDA hold 9, 17, 17, 25, 25, 33 and 33. Codes 0x39..0x3F give sixteen times those dividers, with SDA hold 129, 257, 257, 385, 385, 513 and 513. The SDA hold is always shorter than half the divider.
- R3: With half = divider/2, the start hold is half-2 cycles and the stop hold is half+1 cycles.
- R4: START is accepted only when idle. On the accepting edge sda_oe goes to 1 while SCL stays released. After the start hold, scl_oe goes to 1 in the same cycle as done_tick.
- R5: A data bit (sda_oe = NOT bit_val, so a 0 pulls SDA low) holds SCL low for half cycles from the accepting edge. SDA takes the new value SDA-hold cycles after that edge. SCL is then released for half cycles, with SDA steady. Finally SCL is pulled low together with done_tick.
- R6: A repeated START releases SDA SDA-hold cycles after acceptance. SCL stays low for half cycles and is then released for half cycles. SDA is then pulled low for the start hold, after which SCL is pulled low with done_tick.
- R7: STOP pulls SDA low SDA-hold cycles after acceptance and releases SCL after half cycles. It releases SDA stop-hold cycles later, with done_tick, leaving the block idle.
- R8: Data bit, repeated START and STOP are accepted only after START, while the block is not busy. If several are requested together, STOP wins over repeated START, which wins over data bit. Any request made while busy, or in the wrong state, has no effect.
- R9: The rate code is sampled only on the accepting edge. Changing it during a phase does not alter that phase's timing.
- R10: An unsupported code at acceptance uses the timing of FALLBACK_CODE (default 0x19) and sets rate_err. rate_err stays 1 until reset.
- R11: done_tick is a single-cycle pulse. busy is 1 from the cycle after acceptance until the cycle carrying done_tick, where it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_code | input | 6 | Clock-rate code, sampled when a request is accepted |
| start_req | input | 1 | Request a START condition |
| bit_req | input | 1 | Request one data bit |
| bit_val | input | 1 | Value of the requested data bit |
| rstart_req | input | 1 | Request a repeated START |
| stop_req | input | 1 | Request a STOP condition |
| scl_oe | output | 1 | SCL pull-down enable (1 drives low) |
| sda_oe | output | 1 | SDA pull-down enable (1 drives low) |
| done_tick | output | 1 | One-cycle pulse when a phase completes |
| busy | output | 1 | A phase is in progress |
| rate_err | output | 1 | Sticky flag: an unsupported code was used |

## Verification
The bench builds the block with its default FALLBACK_CODE of 0x19. It then sweeps all fourteen supported codes, running START, both bit values, repeated START and STOP at full divider length. Each phase is timed by counting cycles in every SCL/SDA combination, so every divider, SDA hold, start hold and stop hold is compared with the value worked out arithmetically. The unsupported code 0x00 exercises the fallback timing and the sticky flag. Requests raised in the wrong state, requests raised while busy, a rate change in mid-phase and simultaneous requests exercise acceptance and priority.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

    localparam int CODE_W   = 6;
    localparam int MAX_DIV  = 3840;
    localparam int TIME_W   = $clog2(MAX_DIV + 1);
    localparam int HI_SHIFT = 4;   // upper group runs sixteen times slower

    typedef logic [TIME_W-1:0] tcount_t;
    typedef logic [CODE_W-1:0] rate_t;

    typedef struct packed {
        tcount_t half;
        tcount_t sda_hold;
        tcount_t start_hold;
        tcount_t stop_hold;
    } phase_times_t;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_HELD,
        PH_START,
        PH_BLO,
        PH_BHI,
        PH_RLO,
        PH_RHI,
        PH_RHOLD,
        PH_PLO,
        PH_PHI
    } phase_e;

    // Divider of the lower group, index 0..6
    function automatic tcount_t base_divider(input logic [2:0] idx);
        case (idx)
            3'd0:    return tcount_t'(96);
            3'd1:    return tcount_t'(112);
            3'd2:    return tcount_t'(128);
            3'd3:    return tcount_t'(144);
            3'd4:    return tcount_t'(160);
            3'd5:    return tcount_t'(192);
            3'd6:    return tcount_t'(240);
            default: return tcount_t'(96);
        endcase
    endfunction

    // Lower-group SDA hold: 9 plus 8 per pair of steps
    function automatic tcount_t base_sda_hold(input logic [2:0] idx);
        logic [3:0] step;
        step = ({1'b0, idx} + 4'd1) >> 1;
        return tcount_t'(9) + tcount_t'({step, 3'b000});
    endfunction

    function automatic logic code_supported(input rate_t c);
        return (c[4:3] == 2'b11) && (c[2:0] != 3'd0);
    endfunction

    function automatic phase_times_t times_for(input rate_t c);
        phase_times_t t;
        logic [2:0]   idx;
        tcount_t      d;
        tcount_t      s;
        idx = c[2:0] - 3'd1;
        d   = base_divider(idx);
        s   = base_sda_hold(idx);
        if (c[CODE_W-1]) begin
            d = d << HI_SHIFT;
            s = ((s - tcount_t'(1)) << HI_SHIFT) + tcount_t'(1);
        end
        t.half       = d >> 1;
        t.sda_hold   = s;
        t.start_hold = t.half - tcount_t'(2);
        t.stop_hold  = t.half + tcount_t'(1);
        return t;
    endfunction

endpackage

// File: rtl/scl_rate_decode.sv
module scl_rate_decode
    import scl_timing_pkg::*;
#(
    parameter int unsigned FALLBACK_CODE = 6'h19
) (
    input  rate_t        code,
    output phase_times_t times,
    output logic         code_ok
);

    localparam rate_t FB = rate_t'(FALLBACK_CODE);

    always_comb begin
        code_ok = code_supported(code);
        times   = code_ok ? times_for(code) : times_for(FB);
    end

    always_comb begin
        a_r2_hold_inside_low: assert (times.sda_hold < times.half);
    end

endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
    import scl_timing_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  phase_times_t times_in,
    input  logic         code_ok,
    input  logic         start_req,
    input  logic         bit_req,
    input  logic         bit_val,
    input  logic         rstart_req,
    input  logic         stop_req,
    output logic         scl_oe,
    output logic         sda_oe,
    output logic         done_tick,
    output logic         busy,
    output logic         rate_err
);

    phase_e       st_q;
    tcount_t      cnt_q;
    phase_times_t t_q;
    logic         bit_q;
    logic         scl_q, sda_q, done_q, err_q;

    logic    take;
    phase_e  next_ph;
    logic    at_sda, at_half, at_start, at_stop;

    always_comb begin
        take    = 1'b0;
        next_ph = st_q;
        if (st_q == PH_IDLE) begin
            if (start_req) begin
                take    = 1'b1;
                next_ph = PH_START;
            end
        end else if (st_q == PH_HELD) begin
            if (stop_req) begin
                take    = 1'b1;
                next_ph = PH_PLO;
            end else if (rstart_req) begin
                take    = 1'b1;
                next_ph = PH_RLO;
            end else if (bit_req) begin
                take    = 1'b1;
                next_ph = PH_BLO;
            end
        end
    end

    always_comb begin
        at_sda   = (cnt_q == t_q.sda_hold   - tcount_t'(1));
        at_half  = (cnt_q == t_q.half       - tcount_t'(1));
        at_start = (cnt_q == t_q.start_hold - tcount_t'(1));
        at_stop  = (cnt_q == t_q.stop_hold  - tcount_t'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PH_IDLE;
            cnt_q  <= '0;
            t_q    <= '0;
            bit_q  <= 1'b0;
            scl_q  <= 1'b0;
            sda_q  <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            cnt_q  <= cnt_q + tcount_t'(1);
            case (st_q)
                PH_IDLE, PH_HELD: begin
                    cnt_q <= '0;
                    if (take) begin
                        st_q  <= next_ph;
                        t_q   <= times_in;
                        bit_q <= bit_val;
                        err_q <= err_q | ~code_ok;
                        if (next_ph == PH_START) sda_q <= 1'b1;
                    end
                end
                PH_START: begin
                    if (at_start) begin
                        scl_q  <= 1'b1;
                        done_q <= 1'b1;
                        st_q   <= PH_HELD;
                    end
                end
                PH_BLO: begin
                    if (at_sda) sda_q <= ~bit_q;
                    if (at_half) begin
                        scl_q <= 1'b0;
                        cnt_q <= '0;
                        st_q  <= PH_BHI;
                    end
                end
                PH_BHI: begin
                    if (at_half) begin
                        scl_q  <= 1'b1;
                        done_q <= 1'b1;
                        st_q   <= PH_HELD;
                    end
                end
                PH_RLO: begin
                    if (at_sda) sda_q <= 1'b0;
                    if (at_half) begin
                        scl_q <= 1'b0;
                        cnt_q <= '0;
                        st_q  <= PH_RHI;
                    end
                end
                PH_RHI: begin
                    if (at_half) begin
                        sda_q <= 1'b1;
                        cnt_q <= '0;
                        st_q  <= PH_RHOLD;
                    end
                end
                PH_RHOLD: begin
                    if (at_start) begin
                        scl_q  <= 1'b1;
                        done_q <= 1'b1;
                        st_q   <= PH_HELD;
                    end
                end
                PH_PLO: begin
                    if (at_sda) sda_q <= 1'b1;
                    if (at_half) begin
                        scl_q <= 1'b0;
                        cnt_q <= '0;
                        st_q  <= PH_PHI;
                    end
                end
                PH_PHI: begin
                    if (at_stop) begin
                        sda_q  <= 1'b0;
                        done_q <= 1'b1;
                        st_q   <= PH_IDLE;
                    end
                end
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    assign scl_oe    = scl_q;
    assign sda_oe    = sda_q;
    assign done_tick = done_q;
    assign rate_err  = err_q;
    assign busy      = (st_q != PH_IDLE) && (st_q != PH_HELD);

    // R4: while the start hold runs, SCL is released and SDA is pulled low
    a_r4_start_lines: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_START) |-> (!scl_q && sda_q));

    // R5: SDA does not move while SCL is high during a data bit
    a_r5_sda_steady_high: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_BHI) |=> $stable(sda_q));

    // R7: SCL is released and SDA still low throughout the stop hold
    a_r7_stop_hold_lines: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_PHI) |-> (!scl_q && sda_q));

    // R1/R8: an idle block leaves both lines released
    a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_IDLE) |-> (!scl_q && !sda_q));

    // R10: the error flag never clears without reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    // R11: the completion tick lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_timing_pkg::*;
#(
    parameter int unsigned FALLBACK_CODE = 6'h19
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] rate_code,
    input  logic       start_req,
    input  logic       bit_req,
    input  logic       bit_val,
    input  logic       rstart_req,
    input  logic       stop_req,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       done_tick,
    output logic       busy,
    output logic       rate_err
);

    phase_times_t times;
    logic         code_ok;

    scl_rate_decode #(
        .FALLBACK_CODE(FALLBACK_CODE)
    ) u_decode (
        .code    (rate_t'(rate_code)),
        .times   (times),
        .code_ok (code_ok)
    );

    scl_phase_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .times_in   (times),
        .code_ok    (code_ok),
        .start_req  (start_req),
        .bit_req    (bit_req),
        .bit_val    (bit_val),
        .rstart_req (rstart_req),
        .stop_req   (stop_req),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .done_tick  (done_tick),
        .busy       (busy),
        .rate_err   (rate_err)
    );

endmodule

// File: tb/scl_timing_gen_bench.sv
module scl_timing_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    localparam int LO_DIV[7] = '{96, 112, 128, 144, 160, 192, 240};
    localparam int LO_SDA[7] = '{9, 17, 17, 25, 25, 33, 33};
    localparam int HI_SDA[7] = '{129, 257, 257, 385, 385, 513, 513};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] rate_code = 6'h19;
    logic       start_req = 1'b0;
    logic       bit_req = 1'b0;
    logic       bit_val = 1'b0;
    logic       rstart_req = 1'b0;
    logic       stop_req = 1'b0;
    logic       scl_oe, sda_oe, done_tick, busy, rate_err;

    int n_cmp = 0;
    int n_bad = 0;

    int   r_low, r_hirel, r_hilow, r_sda1, r_busybad;
    logic r_scl, r_sda, r_timeout;

    always #(CLK_PERIOD/2) clk = ~clk;

    scl_timing_gen u_scl_timing_gen (
        .clk        (clk),
        .rst        (rst),
        .rate_code  (rate_code),
        .start_req  (start_req),
        .bit_req    (bit_req),
        .bit_val    (bit_val),
        .rstart_req (rstart_req),
        .stop_req   (stop_req),
        .scl_oe     (scl_oe),
        .sda_oe     (sda_oe),
        .done_tick  (done_tick),
        .busy       (busy),
        .rate_err   (rate_err)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_cmp++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (code 0x%02h)", req, actual, expected, rate_code);
        end
    endtask

    function automatic int exp_div(input logic [5:0] c);
        int idx;
        if (!(c[4:3] == 2'b11 && c[2:0] != 3'd0)) return 96;
        idx = int'(c[2:0]) - 1;
        return c[5] ? LO_DIV[idx] * 16 : LO_DIV[idx];
    endfunction

    function automatic int exp_sda(input logic [5:0] c);
        int idx;
        if (!(c[4:3] == 2'b11 && c[2:0] != 3'd0)) return 9;
        idx = int'(c[2:0]) - 1;
        return c[5] ? HI_SDA[idx] : LO_SDA[idx];
    endfunction

    // kind: 0 start, 1 bit, 2 repeated start, 3 stop, 4 rstart+bit, 5 stop+rstart+bit
    task automatic run_op(input int kind, input logic bv, input int inject_at);
        logic sda0;
        logic moved;
        int   n;
        @(negedge clk);
        sda0 = sda_oe;
        bit_val    = bv;
        start_req  = (kind == 0);
        bit_req    = (kind == 1) || (kind == 4) || (kind == 5);
        rstart_req = (kind == 2) || (kind == 4) || (kind == 5);
        stop_req   = (kind == 3) || (kind == 5);
        @(negedge clk);
        start_req = 1'b0; bit_req = 1'b0; rstart_req = 1'b0; stop_req = 1'b0;
        r_low = 0; r_hirel = 0; r_hilow = 0; r_sda1 = 0; r_busybad = 0;
        r_timeout = 1'b0;
        moved = 1'b0;
        n = 0;
        forever begin
            if (n == inject_at) begin
                stop_req  = 1'b1;
                rate_code = 6'h3F;
            end else if (n == inject_at + 1) begin
                stop_req  = 1'b0;
                rate_code = 6'h19;
            end
            if (done_tick) begin
                if (busy) r_busybad++;
                break;
            end
            if (!busy) r_busybad++;
            if (scl_oe) r_low++;
            else if (sda_oe) r_hilow++;
            else r_hirel++;
            if (!moved && sda_oe == sda0) r_sda1++;
            else moved = 1'b1;
            n++;
            if (n > 20000) begin
                r_timeout = 1'b1;
                break;
            end
            @(negedge clk);
        end
        r_scl = scl_oe;
        r_sda = sda_oe;
        check("R11 phase completes", int'(r_timeout), 0);
        check("R11 busy during phase", r_busybad, 0);
    endtask

    task automatic full_sequence(input logic [5:0] c);
        int h, s;
        rate_code = c;
        h = exp_div(c) / 2;
        s = exp_sda(c);
        // START
        run_op(0, 1'b0, -5);
        check("R4 R3 start hold", r_hilow, h - 2);
        check("R4 scl low at done", int'(r_scl), 1);
        check("R4 sda low at done", int'(r_sda), 1);
        // bit 1
        run_op(1, 1'b1, -5);
        check("R5 R2 bit1 low time", r_low, h);
        check("R5 R2 bit1 high time", r_hirel, h);
        check("R5 R2 bit1 sda hold", r_sda1, s);
        check("R5 bit1 final", {r_scl, r_sda}, 2'b10);
        // bit 0
        run_op(1, 1'b0, -5);
        check("R5 bit0 low time", r_low, h);
        check("R5 bit0 high time", r_hilow, h);
        check("R5 R2 bit0 sda hold", r_sda1, s);
        check("R5 bit0 final", {r_scl, r_sda}, 2'b11);
        // repeated START
        run_op(2, 1'b0, -5);
        check("R6 rstart low time", r_low, h);
        check("R6 rstart high released", r_hirel, h);
        check("R6 R3 rstart hold", r_hilow, h - 2);
        check("R6 rstart sda hold", r_sda1, s);
        check("R6 rstart final", {r_scl, r_sda}, 2'b11);
        // bit 1 then STOP
        run_op(1, 1'b1, -5);
        run_op(3, 1'b0, -5);
        check("R7 stop low time", r_low, h);
        check("R7 R3 stop hold", r_hilow, h + 1);
        check("R7 stop sda hold", r_sda1, s);
        check("R7 stop final", {r_scl, r_sda}, 2'b00);
        check("R10 no error on valid code", int'(rate_err), 0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 scl_oe", int'(scl_oe), 0);
        check("R1 sda_oe", int'(sda_oe), 0);
        check("R1 done_tick", int'(done_tick), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 rate_err", int'(rate_err), 0);

        // R8: data bit while idle is ignored
        bit_req = 1'b1; bit_val = 1'b0;
        @(negedge clk);
        bit_req = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 bit in idle ignored", {busy, scl_oe, sda_oe}, 3'b000);

        // R2..R7 sweep over every supported code
        for (int ci = 0; ci < 14; ci++) begin
            full_sequence(ci < 7 ? 6'(6'h19 + ci) : 6'(6'h39 + ci - 7));
        end

        // R8: START while held is ignored
        rate_code = 6'h19;
        run_op(0, 1'b0, -5);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 start in held ignored", {busy, scl_oe, sda_oe}, 3'b011);

        // R8/R9: stop request and rate change during a bit have no effect
        run_op(1, 1'b0, 3);
        check("R9 low time kept", r_low, 48);
        check("R9 high time kept", r_hilow, 48);
        repeat (4) @(negedge clk);
        check("R8 stop during busy ignored", {busy, scl_oe, sda_oe}, 3'b011);

        // R8 priority: repeated START over bit
        run_op(4, 1'b1, -5);
        check("R8 rstart beats bit", r_hilow, 46);
        check("R8 rstart beats bit final", {r_scl, r_sda}, 2'b11);
        // R8 priority: STOP over the others
        run_op(5, 1'b1, -5);
        check("R8 stop wins", r_hilow, 49);
        check("R8 stop wins final", {r_scl, r_sda}, 2'b00);
        check("R8 idle after stop", int'(busy), 0);

        // R10: unsupported code falls back and latches the error
        rate_code = 6'h00;
        run_op(0, 1'b0, -5);
        check("R10 fallback start hold", r_hilow, 46);
        check("R10 error set", int'(rate_err), 1);
        run_op(3, 1'b0, -5);
        check("R10 fallback low time", r_low, 48);
        check("R10 fallback stop hold", r_hilow, 49);
        rate_code = 6'h1A;
        run_op(0, 1'b0, -5);
        run_op(3, 1'b0, -5);
        check("R10 error sticky", int'(rate_err), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 R1 error cleared by reset", int'(rate_err), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule